// File: doc/BRIEF.md
# NAND Chunk Hamming Checker and Corrector

This block checks each 512-byte chunk of a NAND page against its 3-byte Hamming code and repairs a single flipped bit. For every chunk the host presents two codes through a valid/ready handshake. One is the code read back from the spare area. The other is the code recomputed over the data that was just read. The block XORs the two codes into a 24-bit syndrome, counts its set bits and classifies the chunk as clean, correctable or uncorrectable. For a correctable chunk it reports the byte offset and bit index of the bad bit. It then inverts that bit in a local 512-byte chunk buffer, which the host fills and drains through a simple byte port.

A small page is one chunk, marked as the last chunk. A large page is four chunks sent in order, with the last flag on the fourth. The block gives a page result when the last chunk completes, or as soon as a chunk is found uncorrectable. After an uncorrectable chunk, the rest of that page is consumed silently. An erased page, whose stored code is all ones while the recomputed code is all zeros, is accepted as clean.

Top module: `nand_ecc_fix`

## Requirements
- R1: `code_stored` and `code_calc` each carry bytes B0 in bits [7:0], B1 in [15:8] and B2 in [23:16]. When the two codes are identical the chunk result is clean (`res_status` = 2'b00), `res_offset` and `res_bit` are 0, and the buffer is unchanged.
- R2: A chunk is accepted on a rising edge where `chk_valid` and `chk_ready` are both high. `res_done` is high for exactly one cycle, after the second rising edge counted from (and including) the accepting edge. `res_status` is only ever 00 (clean), 01 (corrected) or 10 (uncorrectable).
- R3: With X = stored XOR calc, the syndrome S is built as follows:
  - S[5:0] = B2 bits 7..2
  - S[13:6] = B0
  - S[21:14] = B1
  - S[22] = B2 bit 0
  - S[23] = B2 bit 1
- R4: If exactly 12 bits of S are set, the status is corrected. `res_offset` (9 bits, MSB first) is S[23], S[21], S[19], S[17], S[15], S[13], S[11], S[9], S[7]. `res_bit` (MSB first) is S[5], S[3], S[1]. These fields are 0 for any other status.
- R5: If exactly one bit of S is set, the status is uncorrectable.
- R6: Any other nonzero count gives uncorrectable. The exception is a stored code of 24'hFFFFFF with a computed code of 24'h000000, which gives clean.
- R7: On the rising edge that ends a `res_done` cycle with status corrected, buffer byte `res_offset` has bit `res_bit` inverted. No other buffer bit changes.
- R8: `chk_ready` is low from the cycle after a processed chunk is accepted until the cycle after its `res_done`. A buffer write (`mem_we`) is performed only while `chk_ready` is high and is ignored otherwise. `mem_rdata` always shows byte `mem_addr`.
- R9: `page_done` pulses together with `res_done` when the chunk is the last of its page or is uncorrectable. `page_status` is then 10 if that chunk is uncorrectable, otherwise 01 if any chunk of the page was corrected, otherwise 00.
- R10: After an uncorrectable chunk that is not last, the following chunks are accepted up to and including the next one flagged last. They produce no `res_done` and no buffer change, and the next page starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Chunk codes are presented |
| chk_ready | output | 1 | Block can accept a chunk or buffer write |
| code_stored | input | 24 | Code read from the spare area |
| code_calc | input | 24 | Code recomputed over the chunk data |
| chunk_last | input | 1 | Chunk is the final one of its page |
| mem_we | input | 1 | Buffer byte write strobe |
| mem_addr | input | 9 | Buffer byte address for read and write |
| mem_wdata | input | 8 | Buffer write data |
| mem_rdata | output | 8 | Buffer byte at `mem_addr` |
| res_done | output | 1 | Chunk result valid pulse |
| res_status | output | 2 | Chunk status: 00 clean, 01 corrected, 10 uncorrectable |
| res_offset | output | 9 | Byte offset of the corrected bit |
| res_bit | output | 3 | Bit index of the corrected bit |
| page_done | output | 1 | Page result valid pulse |
| page_status | output | 2 | Page status, same encoding |

## Verification
The classifier is tried with several code pairs:
- Identical codes.
- True single-bit syndromes at the first byte, the last byte and a middle byte. These separate the interleaved offset and bit-index bit picks.
- A 12-bit syndrome that is not a clean pair pattern. This shows the rule is a plain population count.
- One-bit and two-bit syndromes, which land on the two uncorrectable paths.
- The erased pattern, against an all-ones stored code with a nonzero computed code.

Multi-chunk pages check the page status when corrections accumulate and when an early failure makes the remaining chunks silent. A buffer write attempted during a busy window confirms that only the correction touches the buffer then.

// File: rtl/nand_ecc_fix.sv
module nand_ecc_fix (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_valid,
  output logic        chk_ready,
  input  logic [23:0] code_stored,
  input  logic [23:0] code_calc,
  input  logic        chunk_last,
  input  logic        mem_we,
  input  logic [8:0]  mem_addr,
  input  logic [7:0]  mem_wdata,
  output logic [7:0]  mem_rdata,
  output logic        res_done,
  output logic [1:0]  res_status,
  output logic [8:0]  res_offset,
  output logic [2:0]  res_bit,
  output logic        page_done,
  output logic [1:0]  page_status
);
  localparam int CHUNK_BYTES = 512;
  localparam int AW = $clog2(CHUNK_BYTES);
  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_BAD   = 2'b10;

  logic [7:0]    buf_q [CHUNK_BYTES];
  logic          s1_v, s1_last, s1_erased;
  logic [23:0]   s1_syn;
  logic          skip_q, pg_fixed_q;
  logic [1:0]    cls;

  wire [23:0]   x    = code_stored ^ code_calc;
  wire [23:0]   syn  = {x[17], x[16], x[15:8], x[7:0], x[23:18]};
  wire          take = chk_valid && chk_ready;
  wire [4:0]    ones = 5'($countones(s1_syn));
  wire [AW-1:0] off_n = {s1_syn[23], s1_syn[21], s1_syn[19], s1_syn[17], s1_syn[15],
                         s1_syn[13], s1_syn[11], s1_syn[9], s1_syn[7]};
  wire [2:0]    bit_n = {s1_syn[5], s1_syn[3], s1_syn[1]};

  assign chk_ready = !s1_v && !res_done;
  assign mem_rdata = buf_q[mem_addr];

  always_comb begin
    if (s1_syn == 24'd0)    cls = ST_CLEAN;
    else if (ones == 5'd12) cls = ST_FIXED;
    else if (ones != 5'd1 && s1_erased) cls = ST_CLEAN;
    else                    cls = ST_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_last   <= 1'b0;
      s1_erased <= 1'b0;
      s1_syn    <= '0;
      skip_q    <= 1'b0;
    end else begin
      s1_v <= take && !skip_q;
      if (take) begin
        s1_syn    <= syn;
        s1_last   <= chunk_last;
        s1_erased <= (code_stored == 24'hFFFFFF) && (code_calc == 24'h0);
      end
      if (take && skip_q && chunk_last) skip_q <= 1'b0;
      else if (s1_v && cls == ST_BAD && !s1_last) skip_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done    <= 1'b0;
      res_status  <= ST_CLEAN;
      res_offset  <= '0;
      res_bit     <= '0;
      page_done   <= 1'b0;
      page_status <= ST_CLEAN;
      pg_fixed_q  <= 1'b0;
    end else begin
      res_done  <= s1_v;
      page_done <= s1_v && (s1_last || cls == ST_BAD);
      if (s1_v) begin
        res_status  <= cls;
        res_offset  <= (cls == ST_FIXED) ? off_n : '0;
        res_bit     <= (cls == ST_FIXED) ? bit_n : '0;
        page_status <= (cls == ST_BAD) ? ST_BAD :
                       (pg_fixed_q || cls == ST_FIXED) ? ST_FIXED : ST_CLEAN;
        pg_fixed_q  <= (s1_last || cls == ST_BAD) ? 1'b0 : (pg_fixed_q || cls == ST_FIXED);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (res_done && res_status == ST_FIXED)
      buf_q[res_offset] <= buf_q[res_offset] ^ (8'd1 << res_bit);
    else if (mem_we && chk_ready)
      buf_q[mem_addr] <= mem_wdata;
  end

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> !chk_ready);
  assert_result_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !skip_q) |=> ##1 res_done);
  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_status != 2'b11);
  assert_page_with_chunk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> res_done);
  assert_skip_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && skip_q) |=> ##1 !res_done);
  assert_fix_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status != ST_FIXED) |-> (res_offset == '0 && res_bit == '0));
endmodule

// File: tb/nand_ecc_fix_test.sv
module nand_ecc_fix_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_valid = 1'b0, chunk_last = 1'b0, mem_we = 1'b0;
  logic [23:0] code_stored = '0, code_calc = '0;
  logic [8:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic chk_ready, res_done, page_done;
  logic [7:0] mem_rdata;
  logic [1:0] res_status, page_status;
  logic [8:0] res_offset;
  logic [2:0] res_bit;

  int nchk = 0, nerr = 0;
  bit started = 0;

  always #4 clk = ~clk;

  nand_ecc_fix uut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .code_stored(code_stored), .code_calc(code_calc), .chunk_last(chunk_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .res_done(res_done), .res_status(res_status), .res_offset(res_offset), .res_bit(res_bit),
    .page_done(page_done), .page_status(page_status));

  task automatic check(input int act, input int exp, input string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  // bus bit position feeding syndrome bit k
  function automatic int src_of(input int k);
    if (k < 6) return 18 + k;
    else if (k < 14) return k - 6;
    else if (k < 22) return 8 + (k - 14);
    else return 16 + (k - 22);
  endfunction

  function automatic logic [23:0] to_syn(input logic [23:0] xr);
    logic [23:0] s;
    for (int k = 0; k < 24; k++) s[k] = xr[src_of(k)];
    return s;
  endfunction

  function automatic logic [23:0] from_syn(input logic [23:0] s);
    logic [23:0] xr;
    for (int k = 0; k < 24; k++) xr[src_of(k)] = s[k];
    return xr;
  endfunction

  function automatic logic [23:0] pair_syn(input int off, input int bt);
    logic [23:0] s;
    int a;
    a = off * 8 + bt;
    for (int k = 0; k < 12; k++) begin
      s[2*k+1] = a[k];
      s[2*k]   = !a[k];
    end
    return s;
  endfunction

  task automatic classify(input logic [23:0] st, input logic [23:0] ca,
                          output logic [1:0] cs, output logic [8:0] co, output logic [2:0] cb);
    logic [23:0] s;
    int n;
    s = to_syn(st ^ ca);
    n = 0;
    for (int k = 0; k < 24; k++) n += s[k];
    co = '0; cb = '0;
    if (n == 0) cs = 2'b00;
    else if (n == 12) begin
      cs = 2'b01;
      for (int i = 0; i < 9; i++) co[i] = s[7 + 2*i];
      for (int i = 0; i < 3; i++) cb[i] = s[1 + 2*i];
    end else if (n != 1 && st == 24'hFFFFFF && ca == 24'h0) cs = 2'b00;
    else cs = 2'b10;
  endtask

  // reference model
  logic [7:0] exp_mem [512];
  logic m1v, m1last, mdone, mpd, mskip, mpgfix;
  logic [1:0] m1st, mst, mps;
  logic [8:0] m1off, moff;
  logic [2:0] m1bt, mbt;
  wire mready = !m1v && !mdone;

  always @(posedge clk) begin
    logic [1:0] cs; logic [8:0] co; logic [2:0] cb;
    logic acc;
    if (!rst_n) begin
      m1v <= 0; m1last <= 0; mdone <= 0; mpd <= 0; mskip <= 0; mpgfix <= 0;
      m1st <= 0; mst <= 0; mps <= 0; m1off <= 0; moff <= 0; m1bt <= 0; mbt <= 0;
    end else begin
      acc = chk_valid && mready;
      if (mdone && mst == 2'b01) exp_mem[moff] <= exp_mem[moff] ^ (8'd1 << mbt);
      else if (mem_we && mready) exp_mem[mem_addr] <= mem_wdata;
      mdone <= m1v;
      mpd <= m1v && (m1last || m1st == 2'b10);
      if (m1v) begin
        mst <= m1st; moff <= m1off; mbt <= m1bt;
        if (m1st == 2'b10) mps <= 2'b10;
        else if (mpgfix || m1st == 2'b01) mps <= 2'b01;
        else mps <= 2'b00;
        if (m1last || m1st == 2'b10) mpgfix <= 0;
        else if (m1st == 2'b01) mpgfix <= 1;
      end
      m1v <= acc && !mskip;
      if (acc) begin
        classify(code_stored, code_calc, cs, co, cb);
        m1st <= cs; m1off <= co; m1bt <= cb; m1last <= chunk_last;
      end
      if (acc && mskip && chunk_last) mskip <= 0;
      else if (m1v && m1st == 2'b10 && !m1last) mskip <= 1;
    end
  end

  always @(negedge clk) if (started) begin
    check(chk_ready, mready, "R8 ready");
    check(res_done, mdone, "R2 done pulse");
    if (mdone) begin
      check(res_status, mst, "R3 R5 R6 status");
      check(res_offset, moff, "R4 offset");
      check(res_bit, mbt, "R4 bit index");
    end
    check(page_done, mpd, "R9 R10 page_done");
    if (mpd) check(page_status, mps, "R9 page_status");
  end

  task automatic send(input logic [23:0] st, input logic [23:0] ca, input logic last);
    @(negedge clk);
    chk_valid = 1; code_stored = st; code_calc = ca; chunk_last = last;
    @(negedge clk);
    chk_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic mem_chk(input int a, input string what);
    mem_addr = 9'(a);
    #1;
    check(mem_rdata, exp_mem[a], what);
  endtask

  task automatic send_fix(input int off, input int bt, input logic [23:0] ca, input logic last);
    send(ca ^ from_syn(pair_syn(off, bt)), ca, last);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    check(res_done, 0, "R2 reset done");
    check(page_done, 0, "R9 reset page_done");
    check(chk_ready, 1, "R8 reset ready");
    rst_n = 1;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      mem_we = 1; mem_addr = 9'(i); mem_wdata = 8'(i * 7 + 3);
    end
    @(negedge clk); mem_we = 0;
    @(negedge clk);
    mem_chk(0, "R8 fill byte 0");
    mem_chk(300, "R8 fill byte 300");

    send(24'h5A3C91, 24'h5A3C91, 1);          // R1 identical
    mem_chk(0, "R1 buffer untouched");
    send_fix(0, 0, 24'h123456, 1);            // R4 R7 first byte
    mem_chk(0, "R7 byte 0 bit 0");
    mem_chk(1, "R7 neighbour byte 1");
    send_fix(511, 7, 24'hABCDEF, 1);          // R4 R7 last byte
    mem_chk(511, "R7 byte 511 bit 7");
    mem_chk(510, "R7 neighbour byte 510");
    send_fix(341, 5, 24'h0F0F0F, 1);          // R3 R4 middle byte
    mem_chk(341, "R7 byte 341 bit 5");
    send(24'h000FFF ^ from_syn(24'h000FFF) ^ 24'h000FFF, 24'h0, 1); // R4 12-bit non-pair
    mem_chk(7, "R7 byte 7 from plain count");
    send(24'h111111 ^ 24'h000001, 24'h111111, 1);   // R5 one bit
    send(24'h222222 ^ 24'h000300, 24'h222222, 1);   // R6 two bits
    send(24'hFFFFFF, 24'h000000, 1);                // R6 erased
    send(24'hFFFFFF, 24'h000010, 1);                // R6 not erased

    send(24'h1, 24'h1, 0);                          // R9 page with a fix
    send_fix(20, 2, 24'h777777, 0);
    send(24'h2, 24'h2, 0);
    send(24'h3, 24'h3, 1);
    mem_chk(20, "R7 R9 page fix byte 20");

    send(24'h4, 24'h4, 0);                          // R10 early failure
    send(24'h4 ^ 24'h80, 24'h4, 0);
    send_fix(40, 1, 24'h5, 0);
    send_fix(41, 1, 24'h6, 1);
    mem_chk(40, "R10 skipped chunk byte 40");
    mem_chk(41, "R10 skipped chunk byte 41");
    send(24'h9, 24'h9, 1);                          // R9 R10 fresh page
    check(page_status, 0, "R10 fresh page status clean");

    @(negedge clk);                                 // R8 write while busy
    chk_valid = 1; code_stored = 24'hC0FFEE; code_calc = 24'hC0FFEE; chunk_last = 1;
    @(negedge clk);
    chk_valid = 0;
    mem_we = 1; mem_addr = 9'd5; mem_wdata = 8'hAA;
    @(negedge clk); mem_we = 0;
    repeat (3) @(negedge clk);
    mem_chk(5, "R8 busy write ignored");

    repeat (2) @(negedge clk);
    started = 0;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule